// File: doc/BRIEF.md
# Multi-Depth Pixel Serialiser with Palette

This block takes video bytes, one at a time, and spreads each one over a fixed number of pixel clocks as a run of 4-bit palette indices. Each index is then looked up in a 16-entry colour table, giving one bit each of red, green and blue per pixel clock. A 3-bit mode number picks both the colour depth (1, 2 or 4 bits per pixel) and the line width. Modes 0 to 3 are 80-byte modes, with a byte every 8 clocks. Modes 4 to 7 are 40-byte modes, with a byte every 16 clocks. Either way a line of bytes covers 640 pixel clocks.

The lower depths do not fill the low bits of the index. A 1-bit pixel lands on index bit 3 alone. A 2-bit pixel lands on index bits 3 and 1. The bits that form one pixel are interleaved across the byte rather than taken as a contiguous field. The colour table is loaded through a write port of address and data. The output is black whenever the display is not active and whenever no byte is being shown.

The control is a two-state machine. In `ST_IDLE` no byte is held and the output is black. A load takes the transition *start* to `ST_SHOW`. In `ST_SHOW` a counter runs through the byte slot. A load during the slot takes the transition *reload*, which stays in `ST_SHOW` and restarts the slot with the new byte. Reaching the last clock of the slot without a load takes the transition *drain* back to `ST_IDLE`. Otherwise the machine *advances* within `ST_SHOW`.

Top module: `pixser_top`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied, and after it, `rgb` is 000 and every colour table entry is 000.
- R2: In 1 bpp, the byte gives 8 pixels, most significant bit first. A set bit selects index 8 (binary 1000) and a clear bit selects index 0.
- R3: In 2 bpp, the byte gives 4 pixels. Pixel n (n = 0..3) has index bit 3 = byte bit 7−n, index bit 1 = byte bit 3−n, and index bits 2 and 0 = 0.
- R4: In 4 bpp, the byte gives 2 pixels. Pixel 0 has index bits 3..0 = byte bits 7,5,3,1. Pixel 1 has index bits 3..0 = byte bits 6,4,2,0.
- R5: The `mode` input is decoded as follows. Values 1 and 5 select 2 bpp. Value 2 selects 4 bpp. All other values select 1 bpp. Values 4 to 7 are 40-byte modes and values 0 to 3 are 80-byte modes.
- R6: Pixel 0 appears in the cycle after the clock edge that takes the load. Each pixel is held for bpp clocks in 80-byte modes and for 2×bpp clocks in 40-byte modes, so one byte fills 8 or 16 clocks.
- R7: `active` is sampled at each clock edge. If it was low, `rgb` is 000 in the following cycle.
- R8: Before the first load, and after a byte's last clock has passed with no new load, `rgb` is 000.
- R9: A load during a byte slot restarts the slot at pixel 0 with the new byte and mode. The mode is captured at the load, so changes on `mode` between loads do not affect the byte being shown.
- R10: With `pal_we` high, `pal_rgb` is written to entry `pal_addr` at the clock edge. While shown, `rgb` equals the table entry of the current index, and a write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Mode number, captured on load |
| load | input | 1 | Takes `byte_in` and starts a byte slot |
| byte_in | input | 8 | Video byte |
| active | input | 1 | High inside the visible area |
| pal_we | input | 1 | Colour table write enable |
| pal_addr | input | 4 | Colour table entry to write |
| pal_rgb | input | 3 | Colour to write (red, green, blue) |
| rgb | output | 3 | Pixel colour (red, green, blue) |

## Verification
Every input is seen at one clock edge, and its result is due in the cycle that follows, with no other register in between. This holds for loads, mode, `active` and colour table writes. The bench drives inputs on the falling edge. A behavioural model steps once on each rising edge, and the model and `rgb` are compared at the next falling edge, so each result is checked exactly one edge after its stimulus. The model works out the pixel number by dividing the time since the load by the hold length, and forms the index from the byte bits named in R2 to R4. It does not model a shift register.

// File: rtl/pixser_pkg.sv
package pixser_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;
    localparam int RGB_W  = 3;
    localparam int MODE_W = 3;

    // Colour depth code: its value is log2 of the bits per pixel
    typedef enum logic [1:0] {
        DEPTH_1 = 2'd0,
        DEPTH_2 = 2'd1,
        DEPTH_4 = 2'd2
    } depth_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } ser_state_e;

endpackage

// File: rtl/pixser_mode_dec.sv
module pixser_mode_dec
    import pixser_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output depth_e            depth,
    output logic              wide
);

    // The upper half of the mode space is the 40-byte (double-width) set
    assign wide = mode[MODE_W-1];

    always_comb begin
        case (mode)
            3'd1, 3'd5: depth = DEPTH_2;
            3'd2:       depth = DEPTH_4;
            default:    depth = DEPTH_1;
        endcase
    end

endmodule

// File: rtl/pixser_palette.sv
module pixser_palette
    import pixser_pkg::*;
#(
    parameter int ENTRY_W = IDX_W,
    parameter int COLOR_W = RGB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ENTRY_W-1:0] wr_addr,
    input  logic [COLOR_W-1:0] wr_data,
    input  logic [ENTRY_W-1:0] rd_addr,
    output logic [COLOR_W-1:0] rd_data
);

    localparam int ENTRIES = 1 << ENTRY_W;

    logic [COLOR_W-1:0] table_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                table_q[i] <= '0;
            end
        end else if (we) begin
            table_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = table_q[rd_addr];

endmodule

// File: rtl/pixser_shift.sv
module pixser_shift
    import pixser_pkg::*;
#(
    parameter int SLOT_NARROW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] byte_in,
    input  depth_e            depth,
    input  logic              wide,
    input  logic              active,
    output logic [IDX_W-1:0]  idx,
    output logic              visible
);

    localparam int SLOT_WIDE = 2 * SLOT_NARROW;
    localparam int CNT_W     = $clog2(SLOT_WIDE);

    ser_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BYTE_W-1:0] sh_q, sh_d;
    depth_e            depth_q, depth_d;
    logic              wide_q, wide_d;
    logic              act_q;

    logic [2:0]        hold_log;
    logic [CNT_W-1:0]  hold_mask;
    logic [CNT_W-1:0]  last_cnt;
    logic              at_edge;
    logic              at_last;

    // A pixel lasts 2^(depth code + wide) clocks
    assign hold_log  = 3'(depth_q) + 3'(wide_q);
    assign hold_mask = ~({CNT_W{1'b1}} << hold_log);
    assign last_cnt  = wide_q ? CNT_W'(SLOT_WIDE - 1) : CNT_W'(SLOT_NARROW - 1);
    assign at_edge   = (cnt_q & hold_mask) == hold_mask;
    assign at_last   = cnt_q == last_cnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            depth_q <= DEPTH_1;
            wide_q  <= 1'b0;
            act_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            depth_q <= depth_d;
            wide_q  <= wide_d;
            act_q   <= active;
        end
    end

    // Next-state logic: start, reload, advance, drain
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        depth_d = depth_q;
        wide_d  = wide_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin
                    state_d = ST_SHOW;
                    cnt_d   = '0;
                    sh_d    = byte_in;
                    depth_d = depth;
                    wide_d  = wide;
                end
            end
            ST_SHOW: begin
                if (load) begin
                    cnt_d   = '0;
                    sh_d    = byte_in;
                    depth_d = depth;
                    wide_d  = wide;
                end else if (at_last) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                    if (at_edge) begin
                        sh_d = sh_q << 1;
                    end
                end
            end
        endcase
    end

    // Outputs: the current pixel always sits at the top of the shifter
    always_comb begin
        case (depth_q)
            DEPTH_2: idx = {sh_q[7], 1'b0, sh_q[3], 1'b0};
            DEPTH_4: idx = {sh_q[7], sh_q[5], sh_q[3], sh_q[1]};
            default: idx = {sh_q[7], 3'b000};
        endcase
        visible = (state_q == ST_SHOW) && act_q;
    end

endmodule

// File: rtl/pixser_top.sv
module pixser_top
    import pixser_pkg::*;
#(
    parameter int SLOT_NARROW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              load,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              active,
    input  logic              pal_we,
    input  logic [IDX_W-1:0]  pal_addr,
    input  logic [RGB_W-1:0]  pal_rgb,
    output logic [RGB_W-1:0]  rgb
);

    depth_e             dec_depth;
    logic               dec_wide;
    logic [IDX_W-1:0]   pix_idx;
    logic               pix_vis;
    logic [RGB_W-1:0]   pal_out;

    pixser_mode_dec u_dec (
        .mode  (mode),
        .depth (dec_depth),
        .wide  (dec_wide)
    );

    pixser_shift #(
        .SLOT_NARROW (SLOT_NARROW)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .byte_in (byte_in),
        .depth   (dec_depth),
        .wide    (dec_wide),
        .active  (active),
        .idx     (pix_idx),
        .visible (pix_vis)
    );

    pixser_palette u_pal (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (pal_we),
        .wr_addr (pal_addr),
        .wr_data (pal_rgb),
        .rd_addr (pix_idx),
        .rd_data (pal_out)
    );

    assign rgb = pix_vis ? pal_out : '0;

endmodule

// File: rtl/pixser_chk.sv
module pixser_chk
    import pixser_pkg::*;
#(
    parameter int SLOT_NARROW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             active,
    input logic [RGB_W-1:0] rgb,
    input ser_state_e       state,
    input logic [3:0]       cnt,
    input logic             wide_q,
    input depth_e           depth_q,
    input logic [IDX_W-1:0] idx
);

    localparam logic [3:0] LAST_N = 4'(SLOT_NARROW - 1);
    localparam logic [3:0] LAST_W = 4'(2 * SLOT_NARROW - 1);

    // R8
    idle_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> rgb == '0);

    // R7
    inactive_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> rgb == '0);

    // R9
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state == ST_SHOW && cnt == 4'd0));

    // R6
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SHOW |-> cnt <= (wide_q ? LAST_W : LAST_N));

    // R6
    slot_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHOW && !load && cnt == (wide_q ? LAST_W : LAST_N)) |=> state == ST_IDLE);

    // R2
    depth1_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHOW && depth_q == DEPTH_1) |-> idx[2:0] == 3'b000);

    // R3
    depth2_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHOW && depth_q == DEPTH_2) |-> (idx[2] == 1'b0 && idx[0] == 1'b0));

endmodule

bind pixser_top pixser_chk #(.SLOT_NARROW(SLOT_NARROW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .active  (active),
    .rgb     (rgb),
    .state   (u_ser.state_q),
    .cnt     (u_ser.cnt_q),
    .wide_q  (u_ser.wide_q),
    .depth_q (u_ser.depth_q),
    .idx     (pix_idx)
);

// File: tb/tb_pixser_top.sv
module tb_pixser_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = '0;
    logic       load = 1'b0;
    logic [7:0] byte_in = '0;
    logic       active = 1'b0;
    logic       pal_we = 1'b0;
    logic [3:0] pal_addr = '0;
    logic [2:0] pal_rgb = '0;
    logic [2:0] rgb;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural model state
    bit         m_valid = 0;
    logic [7:0] m_byte = '0;
    int         m_bpp = 1;
    bit         m_wide = 0;
    int         m_t = 0;
    bit         m_act = 0;
    logic [2:0] m_pal [16];

    logic [2:0] colours [16] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd0,
                                 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd7};

    pixser_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .load     (load),
        .byte_in  (byte_in),
        .active   (active),
        .pal_we   (pal_we),
        .pal_addr (pal_addr),
        .pal_rgb  (pal_rgb),
        .rgb      (rgb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0;
            m_act   = 0;
            m_t     = 0;
            for (int i = 0; i < 16; i++) m_pal[i] = 3'd0;
        end else begin
            m_act = active;
            if (pal_we) m_pal[pal_addr] = pal_rgb;
            if (load) begin
                m_valid = 1;
                m_byte  = byte_in;
                m_bpp   = (mode == 3'd1 || mode == 3'd5) ? 2 : (mode == 3'd2) ? 4 : 1;
                m_wide  = mode >= 3'd4;
                m_t     = 0;
            end else if (m_valid) begin
                if (m_t == (m_wide ? 16 : 8) - 1) m_valid = 0;
                else m_t++;
            end
        end
    end

    function automatic logic [2:0] expect_rgb();
        int n;
        int hold;
        logic [3:0] ix;
        if (!m_valid || !m_act) return 3'd0;
        hold = m_bpp * (m_wide ? 2 : 1);
        n = m_t / hold;
        case (m_bpp)
            1: ix = {m_byte[7-n], 3'b000};
            2: ix = {m_byte[7-n], 1'b0, m_byte[3-n], 1'b0};
            default: ix = (n == 0) ? {m_byte[7], m_byte[5], m_byte[3], m_byte[1]}
                                   : {m_byte[6], m_byte[4], m_byte[2], m_byte[0]};
        endcase
        return m_pal[ix];
    endfunction

    task automatic tick();
        logic [2:0] exp_v;
        @(negedge clk);
        exp_v = expect_rgb();
        n_chk++;
        if (rgb !== exp_v) begin
            n_bad++;
            $display("FAIL %s t=%0t rgb actual=%b expected=%b", cur_req, $time, rgb, exp_v);
        end
    endtask

    task automatic drive_byte(input logic [2:0] md, input logic [7:0] b, input int blank_at);
        int slot;
        slot = (md >= 3'd4) ? 16 : 8;
        mode = md; byte_in = b; load = 1'b1;
        tick();
        load = 1'b0;
        mode = md ^ 3'b101;   // R9: mode changes between loads must not matter
        byte_in = ~b;
        for (int k = 1; k < slot; k++) begin
            if (k == blank_at) active = 1'b0;
            if (k == blank_at + 2) active = 1'b1;
            tick();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        lf = 32'h1ACE_B00C;
        // R1: output black during reset
        cur_req = "R1";
        active = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        // R8: idle before any load
        cur_req = "R8";
        for (int i = 0; i < 4; i++) tick();
        // R1: colour table cleared by reset, so a shown byte is still black
        cur_req = "R1";
        drive_byte(3'd0, 8'hFF, -1);
        drive_byte(3'd2, 8'h5A, -1);
        // R10: program the table while inactive
        cur_req = "R10";
        active = 1'b0;
        for (int i = 0; i < 16; i++) begin
            pal_we = 1'b1; pal_addr = 4'(i); pal_rgb = colours[i];
            tick();
        end
        pal_we = 1'b0;
        active = 1'b1;
        // R2: 1 bpp in narrow and wide modes
        cur_req = "R2";
        drive_byte(3'd0, 8'hA5, -1);
        drive_byte(3'd3, 8'h3C, -1);
        drive_byte(3'd4, 8'h81, -1);
        drive_byte(3'd6, 8'h6E, -1);
        drive_byte(3'd7, 8'hF0, -1);
        // R3: 2 bpp
        cur_req = "R3";
        drive_byte(3'd1, 8'h1E, -1);
        drive_byte(3'd1, 8'hC6, -1);
        drive_byte(3'd5, 8'h93, -1);
        // R4: 4 bpp
        cur_req = "R4";
        drive_byte(3'd2, 8'h9B, -1);
        drive_byte(3'd2, 8'h64, -1);
        drive_byte(3'd2, 8'hAA, -1);
        // R5: every mode value
        cur_req = "R5";
        for (int m = 0; m < 8; m++) drive_byte(3'(m), 8'hD2, -1);
        // R7: active dropped mid-byte
        cur_req = "R7";
        drive_byte(3'd0, 8'hFF, 3);
        drive_byte(3'd5, 8'hE7, 6);
        // R8: gap with no load
        cur_req = "R8";
        for (int i = 0; i < 10; i++) tick();
        // R9: reload in the middle of a slot
        cur_req = "R9";
        mode = 3'd4; byte_in = 8'hF0; load = 1'b1;
        tick();
        load = 1'b0;
        for (int i = 0; i < 4; i++) tick();
        mode = 3'd2; byte_in = 8'h39; load = 1'b1;
        tick();
        load = 1'b0; mode = 3'd6;
        for (int i = 0; i < 9; i++) tick();
        // R10: table write while a byte is shown
        cur_req = "R10";
        mode = 3'd4; byte_in = 8'hFF; load = 1'b1;
        tick();
        load = 1'b0;
        tick();
        pal_we = 1'b1; pal_addr = 4'd8; pal_rgb = 3'd3;
        tick();
        pal_we = 1'b0;
        for (int i = 0; i < 12; i++) tick();
        pal_we = 1'b1; pal_addr = 4'd8; pal_rgb = colours[8];
        tick();
        pal_we = 1'b0;
        // R6: mixed stream of loads, modes, blanking and writes
        cur_req = "R6";
        for (int i = 0; i < 600; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            load    = lf[3:2] == 2'b00;
            mode    = lf[10:8];
            byte_in = lf[23:16];
            active  = lf[13:11] != 3'b000;
            pal_we  = lf[29:26] == 4'hF;
            pal_addr = lf[7:4];
            pal_rgb  = lf[26:24];
            tick();
        end
        load = 1'b0; pal_we = 1'b0;
        for (int i = 0; i < 20; i++) tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule